// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Encoder

This block is the transmit side of one digital isolation channel. It samples a logic input and reports each change of the level it carries as a short coded burst on a single output line. That line drives the coupling element across an isolation barrier. A receiver on the far side keeps a set/reset latch. The burst code tells that latch whether to go high or low, so the encoder never sends the level itself. The carried level is the inverse of the input pin.

When the input stays quiet, the encoder sends a refresh burst of the present level at a fixed interval. A far side that missed a burst, or that powered up late, therefore still settles to the right DC state. While an undervoltage-lockout input is asserted, the encoder stays silent. When the lockout releases, it sends a refresh of the present level at once and then resumes edge coding. It does this whether or not anything listens on the far side.

All timing is counted in clock cycles through parameters: mark width, space between the two marks of a reset code, quiet guard after each burst, and refresh interval.

Top module: `iso_pulse_encoder`

## Requirements
- R1: The carried level is the inverse of the sampled `din_i`. Carried level high is sent as a set code: one mark of `MARK_LEN` high cycles. Carried level low is sent as a reset code: two marks of `MARK_LEN` high cycles with `SPACE_LEN` low cycles between them.
- R2: A change of `din_i` that is sampled while the encoder is idle raises `pulse_o` from the second rising clock edge after the change. It carries the code of the new carried level.
- R3: Every burst is followed by at least `GUARD_LEN` cycles with `pulse_o` low before the next burst can start.
- R4: While the carried level does not change, a refresh burst of the present level starts after exactly `REFRESH_CYC` idle cycles following the guard. This repeats for as long as the input stays static.
- R5: From the second rising edge after `uvlo_i` is sampled high, `pulse_o` stays low and changes of `din_i` start no burst. A burst already in progress is abandoned.
- R6: After `uvlo_i` falls, and after reset, a refresh burst of the present carried level begins on the second rising edge. This happens even if that level equals the level last sent.
- R7: A change that arrives during a burst is held. Its burst starts one cycle after the guard ends. Changes during a burst that return the input to the level last sent produce no extra burst.
- R8: While `rst` is high, `pulse_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_i | input | 1 | Undervoltage lockout active, high = hold the channel silent |
| din_i | input | 1 | Logic data input to be carried across the barrier |
| pulse_o | output | 1 | Coded pulse line to the barrier coupling element |

## Verification
The bench aims at the moments where the edge path, the refresh timer and the lockout compete. It checks a change that lands in the middle of a burst: a design that dropped it would leave the far side stale until the next refresh, and one that restarted the burst would truncate the running code. It checks a toggle pair that cancels inside a burst: a design that latched raw edges would send a redundant burst and shift the refresh phase. It also checks lockout asserted mid-mark, and release with an unchanged level; a design that only coded changes would send nothing on release. Refresh spacing is checked cycle by cycle for both codes, so an off-by-one in the idle count or the guard shows up directly.

// File: rtl/iso_enc_pkg.sv
package iso_enc_pkg;

    // Burst sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_MARK_A = 3'd1,
        PH_SPACE  = 3'd2,
        PH_MARK_B = 3'd3,
        PH_GUARD  = 3'd4
    } phase_e;

    // Set = one mark, reset = two marks
    typedef enum logic {
        CODE_SET   = 1'b0,
        CODE_RESET = 1'b1
    } code_e;

    typedef struct packed {
        logic  go;
        code_e code;
    } burst_req_t;

    // Carried level high selects the set code
    function automatic code_e code_for_level(input logic lvl);
        return lvl ? CODE_SET : CODE_RESET;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/iso_enc_sampler.sv
module iso_enc_sampler (
    input  logic clk,
    input  logic rst,
    input  logic uvlo_i,
    input  logic din_i,
    output logic lvl_o,
    output logic uvlo_o
);
    logic din_q;
    logic uvlo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= 1'b0;
            uvlo_q <= 1'b1;
        end else begin
            din_q  <= din_i;
            uvlo_q <= uvlo_i;
        end
    end

    // Channel carries the inverse of the pin
    assign lvl_o  = ~din_q;
    assign uvlo_o = uvlo_q;

endmodule

// File: rtl/iso_enc_refresh.sv
module iso_enc_refresh #(
    parameter int unsigned PERIOD = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic due_o
);
    import iso_enc_pkg::*;

    localparam int unsigned TW = cnt_width(PERIOD);

    logic [TW-1:0] cnt;

    assign due_o = run_i && (cnt == TW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || due_o) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R4: idle count never passes the refresh interval
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < TW'(PERIOD));

endmodule

// File: rtl/iso_enc_burst.sv
module iso_enc_burst #(
    parameter int unsigned MARK_LEN  = 2,
    parameter int unsigned SPACE_LEN = 2,
    parameter int unsigned GUARD_LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    abort_i,
    input  iso_enc_pkg::burst_req_t req_i,
    output logic                    idle_o,
    output logic                    pulse_o
);
    import iso_enc_pkg::*;

    localparam int unsigned LMAX = max3(MARK_LEN, SPACE_LEN, GUARD_LEN);
    localparam int unsigned CW   = cnt_width(LMAX);

    phase_e        ph;
    code_e         code_q;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            code_q <= CODE_SET;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (req_i.go) begin
                        ph     <= PH_MARK_A;
                        cnt    <= CW'(MARK_LEN - 1);
                        code_q <= req_i.code;
                    end
                end
                PH_MARK_A: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else if (code_q == CODE_RESET) begin
                        ph  <= PH_SPACE;
                        cnt <= CW'(SPACE_LEN - 1);
                    end else begin
                        ph  <= PH_GUARD;
                        cnt <= CW'(GUARD_LEN - 1);
                    end
                end
                PH_SPACE: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        ph  <= PH_MARK_B;
                        cnt <= CW'(MARK_LEN - 1);
                    end
                end
                PH_MARK_B: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        ph  <= PH_GUARD;
                        cnt <= CW'(GUARD_LEN - 1);
                    end
                end
                PH_GUARD: begin
                    if (!last) cnt <= cnt - 1'b1;
                    else       ph  <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle_o  = (ph == PH_IDLE);
    assign pulse_o = (ph == PH_MARK_A) || (ph == PH_MARK_B);

    // R1: the space between marks exists only inside a reset code
    a_r1_space_is_reset: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SPACE) |-> (code_q == CODE_RESET));

    // R3: a guard phase never jumps straight into a mark
    a_r3_guard_exit: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_GUARD) |=> (ph == PH_GUARD || ph == PH_IDLE));

endmodule

// File: rtl/iso_pulse_encoder.sv
module iso_pulse_encoder #(
    parameter int unsigned MARK_LEN    = 2,
    parameter int unsigned SPACE_LEN   = 2,
    parameter int unsigned GUARD_LEN   = 4,
    parameter int unsigned REFRESH_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic uvlo_i,
    input  logic din_i,
    output logic pulse_o
);
    import iso_enc_pkg::*;

    logic       lvl;
    logic       uvlo_q;
    logic       idle;
    logic       run;
    logic       due;
    logic       wake_q;
    logic       sent_q;
    burst_req_t req;

    iso_enc_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .uvlo_i (uvlo_i),
        .din_i  (din_i),
        .lvl_o  (lvl),
        .uvlo_o (uvlo_q)
    );

    assign run = idle && !uvlo_q;

    iso_enc_refresh #(.PERIOD(REFRESH_CYC)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .run_i (run),
        .due_o (due)
    );

    always_comb begin
        req.go   = run && (wake_q || (lvl != sent_q) || due);
        req.code = code_for_level(lvl);
    end

    // Level last put on the line, and the pending wake-up refresh
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= 1'b1;
            sent_q <= 1'b0;
        end else begin
            if (uvlo_q)      wake_q <= 1'b1;
            else if (req.go) wake_q <= 1'b0;
            if (req.go)      sent_q <= lvl;
        end
    end

    iso_enc_burst #(
        .MARK_LEN  (MARK_LEN),
        .SPACE_LEN (SPACE_LEN),
        .GUARD_LEN (GUARD_LEN)
    ) u_bst (
        .clk     (clk),
        .rst     (rst),
        .abort_i (uvlo_q),
        .req_i   (req),
        .idle_o  (idle),
        .pulse_o (pulse_o)
    );

    // R5: a sampled lockout silences the line on the next edge
    a_r5_uvlo_quiet: assert property (@(posedge clk) disable iff (rst)
        uvlo_q |=> !pulse_o);

    // R2: an accepted request shows up as a mark one edge later
    a_r2_go_marks: assert property (@(posedge clk) disable iff (rst)
        req.go |=> pulse_o);

    // R7: the sent level cannot move while a burst is running
    a_r7_sent_held: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(sent_q));

    // R6: leaving lockout always finds a wake-up refresh pending
    a_r6_wake_pending: assert property (@(posedge clk) disable iff (rst)
        $fell(uvlo_q) |-> wake_q);

endmodule

// File: tb/sim_iso_pulse_encoder.sv
module sim_iso_pulse_encoder;
    localparam int P  = 2;
    localparam int GP = 2;
    localparam int GU = 3;
    localparam int R  = 20;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic uvlo = 1'b1;
    logic din  = 1'b0;
    logic pulse;
    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 1'b0;

    always #4 clk = ~clk;

    iso_pulse_encoder #(
        .MARK_LEN    (P),
        .SPACE_LEN   (GP),
        .GUARD_LEN   (GU),
        .REFRESH_CYC (R)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .uvlo_i  (uvlo),
        .din_i   (din),
        .pulse_o (pulse)
    );

    task automatic expect_run(input int n, input logic v, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vectors++;
            if (pulse !== v) begin
                errors++;
                $display("FAIL %s: pulse_o=%b expected %b (vector %0d)", tag, pulse, v, vectors);
            end
        end
    endtask

    // Leading low cycle, one mark, guard
    task automatic burst_set(input string tag);
        expect_run(1, 1'b0, tag);
        expect_run(P, 1'b1, {tag, " R1 set mark"});
        expect_run(GU, 1'b0, {tag, " R3 guard"});
    endtask

    // Leading low cycle, mark, space, mark, guard
    task automatic burst_reset(input string tag);
        expect_run(1, 1'b0, tag);
        expect_run(P, 1'b1, {tag, " R1 first mark"});
        expect_run(GP, 1'b0, {tag, " R1 space"});
        expect_run(P, 1'b1, {tag, " R1 second mark"});
        expect_run(GU, 1'b0, {tag, " R3 guard"});
    endtask

    initial begin
        // R8: quiet under reset
        expect_run(4, 1'b0, "R8 reset");
        rst = 1'b0;

        // R5: lockout held, input toggling
        for (int i = 0; i < 10; i++) begin
            din = ~din;
            expect_run(3, 1'b0, "R5 lockout ignores din");
        end

        // R6: release with din low -> carried high -> set code
        uvlo = 1'b0;
        burst_set("R6 wake refresh");

        // R4: periodic refresh of high level
        for (int i = 0; i < 2; i++) begin
            expect_run(R - 1, 1'b0, "R4 idle interval");
            burst_set("R4 refresh high");
        end

        // R2: din rises -> carried low -> reset code
        din = 1'b1;
        burst_reset("R2 din rise");
        expect_run(R - 1, 1'b0, "R4 idle interval");
        burst_reset("R4 refresh low");

        // R2: din falls -> set code
        din = 1'b0;
        burst_set("R2 din fall");

        // R7: change held during a burst
        din = 1'b1;
        expect_run(1, 1'b0, "R7 start");
        expect_run(P, 1'b1, "R7 first mark");
        din = 1'b0;
        expect_run(GP, 1'b0, "R7 space");
        expect_run(P, 1'b1, "R7 second mark");
        expect_run(GU, 1'b0, "R7 guard");
        burst_set("R7 held change");

        // R7: toggle pair inside a burst sends nothing extra
        din = 1'b1;
        expect_run(1, 1'b0, "R7 start");
        expect_run(1, 1'b1, "R7 mark");
        din = 1'b0;
        expect_run(P - 1, 1'b1, "R7 mark");
        din = 1'b1;
        expect_run(GP, 1'b0, "R7 space");
        expect_run(P, 1'b1, "R7 second mark");
        expect_run(GU, 1'b0, "R7 guard");
        expect_run(R - 1, 1'b0, "R7 no extra burst");
        burst_reset("R4 refresh after cancel");

        // R5: lockout mid-mark abandons the burst
        din = 1'b0;
        expect_run(1, 1'b0, "R5 start");
        expect_run(1, 1'b1, "R5 mark");
        uvlo = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            din = ~din;
            expect_run(6, 1'b0, "R5 abort quiet");
        end

        // R6: release with din high -> reset code
        uvlo = 1'b0;
        burst_reset("R6 wake low level");
        expect_run(R - 1, 1'b0, "R4 idle interval");
        burst_reset("R4 refresh low");

        // R6: release with unchanged level still refreshes
        uvlo = 1'b1;
        expect_run(5, 1'b0, "R5 short lockout");
        uvlo = 1'b0;
        burst_reset("R6 no change wake");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule